// File: doc/BRIEF.md
# Button-Controlled Hexadecimal Seconds Counter

This block drives a single seven-segment digit that shows a count from 0 to F. Four push buttons control it. Start puts the counter into a latched run mode, in which the count goes up by one on every one-second tick. Stop leaves run mode. Step adds exactly one to the count while the counter is stopped. Clear resets everything asynchronously. A terminal-count flag is high while the digit shows F.

The start, stop and step buttons pass through two-flop synchronisers clocked by the fast system clock. A prescaler turns that clock into a one-cycle tick enable, so every register runs on one clock and a short press is not lost between ticks. The prescale divisor is a parameter, which lets a testbench use a short tick period. The digit-enable line is active low and is held on permanently, because the block drives only one digit.

Top module: `hexsec_counter`

## Requirements
- R1: While run mode is set, the count goes up by exactly one in every window of TICK_DIV consecutive clock cycles.
- R2: A start press sets run mode, and run mode stays set after the button is released.
- R3: A stop press clears run mode. When stop and start are pressed together, run mode ends up cleared.
- R4: While stopped, each step press adds exactly one to the count, however many cycles the button is held.
- R5: A step press during run mode adds no count beyond the ticks and leaves run mode set.
- R6: Asserting clear sets the count to 0 before the next clock edge and clears run mode. After clear is released, the first tick falls on the TICK_DIV-th rising edge.
- R7: One enabled advance from F gives 0.
- R8: at_max_o is 1 exactly when the count is F.
- R9: seg_n_o is active low with segment a on bit 0 and segment g on bit 6. The glyphs are 0-9, A, b, C, d, E and F.
- R10: digit_en_n_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| clear_i | input | 1 | Clear button, active high, asynchronous |
| start_btn_i | input | 1 | Start button, raw |
| stop_btn_i | input | 1 | Stop button, raw |
| step_btn_i | input | 1 | Single-step button, raw |
| seg_n_o | output | 7 | Segment lines, active low, bit 0 = a |
| digit_en_n_o | output | 1 | Digit enable, active low, tied on |
| at_max_o | output | 1 | High while the count is F |

## Verification
The bench holds step for much longer than a tick period. A design that enables the counter at the button's level, rather than on its rising edge, would then count several times. It presses start and stop in the same cycles, which catches a priority that lets start win and leaves the count moving. It presses step inside a running tick window, where a design that adds the step to the tick would count two in one period. After clear, it checks for no increment on edge TICK_DIV-1 and an increment on edge TICK_DIV. This exposes a prescaler that is not reset, and a sweep of all sixteen values catches wrong glyphs, a missing wrap or a misplaced terminal-count flag.

// File: rtl/hexsec_pkg.sv
package hexsec_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic   run;
        logic   step_prev;
        digit_t count;
    } ctrl_state_t;

    // Active-low glyph, bit 0 = segment a ... bit 6 = segment g
    function automatic logic [6:0] hex_glyph_n(input digit_t v);
        logic [6:0] on;
        case (v)
            4'h0: on = 7'h3F;
            4'h1: on = 7'h06;
            4'h2: on = 7'h5B;
            4'h3: on = 7'h4F;
            4'h4: on = 7'h66;
            4'h5: on = 7'h6D;
            4'h6: on = 7'h7D;
            4'h7: on = 7'h07;
            4'h8: on = 7'h7F;
            4'h9: on = 7'h6F;
            4'hA: on = 7'h77;
            4'hB: on = 7'h7C;
            4'hC: on = 7'h39;
            4'hD: on = 7'h5E;
            4'hE: on = 7'h79;
            default: on = 7'h71;
        endcase
        return ~on;
    endfunction

endpackage

// File: rtl/hexsec_prescaler.sv
module hexsec_prescaler #(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // R1: prescaler state never leaves its range
    a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);

    generate
        if (TICK_DIV > 1) begin : g_gap
            // R1: a tick never lasts two cycles
            a_r1_tick_single: assert property (@(posedge clk_i) disable iff (rst_i)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/hexsec_btn_sync.sv
module hexsec_btn_sync #(
    parameter int N_BTN  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_BTN-1:0] raw_i,
    output logic [N_BTN-1:0] sync_o
);
    generate
        for (genvar b = 0; b < N_BTN; b++) begin : g_btn
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], raw_i[b]};
            end

            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= chain_d;
            end

            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hexsec_ctrl.sv
module hexsec_ctrl
    import hexsec_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   tick_i,
    input  logic   start_i,
    input  logic   stop_i,
    input  logic   step_i,
    output digit_t count_o
);
    ctrl_state_t st_d, st_q;
    logic        step_pulse;
    logic        adv;

    always_comb begin
        st_d       = st_q;
        step_pulse = step_i & ~st_q.step_prev;
        // ticks while running, single step only while stopped
        adv        = st_q.run ? tick_i : step_pulse;

        if (stop_i)       st_d.run = 1'b0;
        else if (start_i) st_d.run = 1'b1;

        st_d.step_prev = step_i;

        if (adv) st_d.count = st_q.count + digit_t'(1);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign count_o = st_q.count;

    // R3: stop always leaves run mode cleared
    a_r3_stop_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        stop_i |=> !st_q.run);

    // R2: start without stop sets run mode
    a_r2_start_sets: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !stop_i) |=> st_q.run);

    // R4: the step edge lasts a single cycle
    a_r4_step_once: assert property (@(posedge clk_i) disable iff (rst_i)
        step_pulse |=> !step_pulse);

    // R1: the count moves by one at most
    a_r1_one_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(st_q.count) |-> st_q.count == $past(st_q.count) + digit_t'(1));

    // R7: wrap from F to 0
    a_r7_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv && st_q.count == 4'hF) |=> st_q.count == 4'h0);

    // R5: no count without a tick while running
    a_r5_no_extra: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.run && !tick_i) |=> $stable(st_q.count));
endmodule

// File: rtl/hexsec_seg_decode.sv
module hexsec_seg_decode
    import hexsec_pkg::*;
(
    input  digit_t     digit_i,
    output logic [6:0] seg_n_o
);
    always_comb begin
        seg_n_o = hex_glyph_n(digit_i);
    end
endmodule

// File: rtl/hexsec_counter.sv
module hexsec_counter
    import hexsec_pkg::*;
#(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic       clk_i,
    input  logic       clear_i,
    input  logic       start_btn_i,
    input  logic       stop_btn_i,
    input  logic       step_btn_i,
    output logic [6:0] seg_n_o,
    output logic       digit_en_n_o,
    output logic       at_max_o
);
    localparam int N_BTN = 3;

    logic             tick;
    logic [N_BTN-1:0] btn_s;
    digit_t           count;

    hexsec_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk_i  (clk_i),
        .rst_i  (clear_i),
        .tick_o (tick)
    );

    hexsec_btn_sync #(.N_BTN(N_BTN), .STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (clear_i),
        .raw_i  ({step_btn_i, stop_btn_i, start_btn_i}),
        .sync_o (btn_s)
    );

    hexsec_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (clear_i),
        .tick_i  (tick),
        .start_i (btn_s[0]),
        .stop_i  (btn_s[1]),
        .step_i  (btn_s[2]),
        .count_o (count)
    );

    hexsec_seg_decode u_dec (
        .digit_i (count),
        .seg_n_o (seg_n_o)
    );

    assign at_max_o     = &count;
    assign digit_en_n_o = 1'b0;

    // R8: the flag rises only on the advance from E
    a_r8_max_entry: assert property (@(posedge clk_i) disable iff (clear_i)
        $rose(at_max_o) |-> $past(count) == 4'hE);
endmodule

// File: tb/hexsec_counter_tb.sv
module hexsec_counter_tb;
    localparam int DIV = 20;

    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       start_b = 1'b0, stop_b = 1'b0, step_b = 1'b0;
    logic [6:0] seg_n;
    logic       den_n, at_max;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    hexsec_counter #(.TICK_DIV(DIV)) u_dut (
        .clk_i        (clk),
        .clear_i      (clear),
        .start_btn_i  (start_b),
        .stop_btn_i   (stop_b),
        .step_btn_i   (step_b),
        .seg_n_o      (seg_n),
        .digit_en_n_o (den_n),
        .at_max_o     (at_max)
    );

    function automatic logic [6:0] exp_seg(input int v);
        logic [6:0] g [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return ~g[v & 15];
    endfunction

    function automatic int shown();
        for (int i = 0; i < 16; i++)
            if (seg_n == exp_seg(i)) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic press(ref logic b, input int cycles);
        @(negedge clk) b = 1'b1;
        repeat (cycles) @(negedge clk);
        b = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        check(shown() == 0, "R6 reset count", shown(), 0);
        check(at_max == 1'b0, "R8 reset flag", at_max, 0);
        check(den_n == 1'b0, "R10 digit enable", den_n, 0);
    endtask

    task automatic t_step_hold();
        int v = shown();
        press(step_b, 3 * DIV);
        check(shown() == ((v + 1) & 15), "R4 long step press", shown(), (v + 1) & 15);
        press(step_b, 2);
        check(shown() == ((v + 2) & 15), "R4 second step", shown(), (v + 2) & 15);
    endtask

    task automatic t_run();
        int v;
        press(start_b, 3);
        for (int w = 0; w < 3; w++) begin
            @(negedge clk) v = shown();
            repeat (DIV) @(posedge clk);
            @(negedge clk);
            check(shown() == ((v + 1) & 15), "R1/R2 one per window", shown(), (v + 1) & 15);
        end
    endtask

    task automatic t_step_while_running();
        int v;
        @(negedge clk) v = shown();
        step_b = 1'b1;
        repeat (5) @(negedge clk);
        step_b = 1'b0;
        repeat (DIV - 5) @(posedge clk);
        @(negedge clk);
        check(shown() == ((v + 1) & 15), "R5 step during run", shown(), (v + 1) & 15);
        v = shown();
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        check(shown() == ((v + 1) & 15), "R5 still running", shown(), (v + 1) & 15);
    endtask

    task automatic t_stop_start_together();
        int v;
        @(negedge clk) begin start_b = 1'b1; stop_b = 1'b1; end
        repeat (3) @(negedge clk);
        start_b = 1'b0; stop_b = 1'b0;
        repeat (3) @(negedge clk);
        v = shown();
        repeat (2 * DIV) @(negedge clk);
        check(shown() == v, "R3 stop wins over start", shown(), v);
    endtask

    task automatic t_clear();
        press(start_b, 3);
        repeat (DIV + 3) @(negedge clk);
        #2 clear = 1'b1;
        #1 check(shown() == 0, "R6 async clear", shown(), 0);
        repeat (3) @(negedge clk);
        clear = 1'b0;
        repeat (2 * DIV) @(negedge clk);
        check(shown() == 0, "R6 run cleared", shown(), 0);
        // second clear: prescaler phase restarts
        clear = 1'b1;
        repeat (2) @(negedge clk);
        clear = 1'b0; start_b = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) start_b = 1'b0;
        repeat (DIV - 4) @(posedge clk);
        @(negedge clk);
        check(shown() == 0, "R6 no tick before edge DIV", shown(), 0);
        @(posedge clk);
        @(negedge clk);
        check(shown() == 1, "R6 tick on edge DIV", shown(), 1);
        press(stop_b, 3);
    endtask

    task automatic t_sweep();
        int v;
        clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            check(seg_n == exp_seg(i), "R9 glyph", seg_n, exp_seg(i));
            check(at_max == (i == 15), "R8 flag", at_max, i == 15);
            if (i < 15) press(step_b, 2);
        end
        press(step_b, 2);
        v = shown();
        check(v == 0, "R7 wrap F to 0", v, 0);
        check(at_max == 1'b0, "R8 flag after wrap", at_max, 0);
        check(den_n == 1'b0, "R10 digit enable", den_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_step_hold();
        t_run();
        t_step_while_running();
        t_stop_start_together();
        t_clear();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule